// File: doc/BRIEF.md
# Configuration Port Controller for a Multi-Function Peripheral Chip

This block is the register front end of a multi-function I/O controller. Software reaches it through two adjacent addresses on an 8-bit I/O bus. The even address selects a register and the odd address carries that register's data. The block stays locked until a key byte arrives. While it is open it holds the chip-wide control registers at indices 0x00 to 0x2F. From index 0x30 upward it holds one register bank per logical device, and the device-number register picks which bank is used.

Each write is masked according to its target register. The chip identifier reads back as a fixed value. The block can exit configuration mode on its own after a specific control write. A strap input can move the whole port pair elsewhere. A second strap selects an alternate access scheme. In that scheme, touching one fixed address opens the block and touching another closes it, and the index and data ports sit at fixed addresses. Every accepted write leaves the block as a one-cycle strobe carrying the index, the device number and the stored value, so that the decoders of the peripherals can update.

Top module: `cfg_port_ctrl`

## Requirements
- R1: A synchronous active-high reset leaves the block locked. After reset, register 0x22 reads 0x39, register 0x24 reads 0x04, register 0x27 reads 0x03, and register 0x26 reads 0xF0, or 0x70 when `base_strap` is high. Every other stored register reads 0x00.
- R2: In normal mode the port pair sits at the 16-bit base {reg 0x27, reg 0x26} with bit 0 cleared. The even address is the index port and the odd address is the data port. Accesses to any other address change nothing and read 0xFF.
- R3: While locked, a write of 0x55 to the index port opens configuration mode. Any other byte, or 0x55 written to the data port, leaves the block locked.
- R4: While open, a write of 0xAA to the index port locks the block. Any other index byte, 0x55 included, becomes the selected register. A read of the index port returns the selected register.
- R5: While locked, data-port writes are ignored and reads of either port return 0xFF.
- R6: Register 0x20 always reads 0x47, and writes to it have no effect.
- R7: The global registers apply these write masks: 0x22 and 0x23 keep bits 0x39, 0x24 keeps bits 0x4E, and 0x02, 0x07, 0x26, 0x27 and 0x2B to 0x2F keep all bits. Writes to any other index below 0x30 are ignored.
- R8: A data write of 0x02 to register 0x02 stores the value and locks the block. Any other value written there is stored and the block stays open.
- R9: A write to 0x26 or 0x27 moves the port pair, starting with the next access.
- R10: Indices 0x30 to 0xFF access the bank of the device named in register 0x07, which stores full bytes. Device numbers above 8 make data writes ignored and data reads return 0xFF.
- R11: When `alt_mode` is high, a read or write at 0xFB unlocks the block and one at 0xF9 locks it. 0xEA is the index port and 0xEB is the data port. 0x55 and 0xAA are ordinary index values, and the base pair does not respond.
- R12: One cycle after a data write is accepted into a stored register, `wr_strobe` is high for one cycle with `wr_index`, `wr_dev` (the value of register 0x07) and `wr_value` (the masked stored byte). Ignored writes raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_mode | input | 1 | Strap: fixed-address lock/unlock scheme |
| base_strap | input | 1 | Strap: reset base 0x0370 instead of 0x03F0 |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per write |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, combinational from current state |
| cfg_active | output | 1 | High while configuration mode is open |
| wr_strobe | output | 1 | One-cycle pulse after an accepted write |
| wr_index | output | 8 | Register index of that write |
| wr_dev | output | 8 | Device number in effect for that write |
| wr_value | output | 8 | Value stored by that write |

## Verification
The bench drives key bytes onto the wrong port and in the wrong state. A design that decoded keys on the data port, or treated 0x55 as a key while open, would leave the lock state or the selected index wrong. It tries masked and unwritable globals, the fixed identifier, and the control-register self-exit with both the exit value and another value. A wrong mask or a missing exit shows up on later reads or in the strobe value. It also selects device numbers just inside and just outside the valid range, moves the port pair, and exercises the alternate scheme. A design that still answered at the old base, or still honoured keys in alternate mode, would diverge from the reference model within a cycle.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
    localparam logic [7:0] KEY_ENTER   = 8'h55;
    localparam logic [7:0] KEY_EXIT    = 8'hAA;
    localparam logic [7:0] CHIP_ID     = 8'h47;
    localparam logic [7:0] IDX_CTRL    = 8'h02;
    localparam logic [7:0] IDX_DEVSEL  = 8'h07;
    localparam logic [7:0] IDX_ID      = 8'h20;
    localparam logic [7:0] IDX_BASE_LO = 8'h26;
    localparam logic [7:0] IDX_BASE_HI = 8'h27;
    localparam logic [7:0] EXIT_VAL    = 8'h02;
    localparam logic [7:0] BANK_START  = 8'h30;
    localparam int         GLOBAL_N    = 48;

    typedef struct packed {
        logic       open;
        logic [7:0] idx;
    } fsm_t;

    typedef struct packed {
        logic       stb;
        logic [7:0] idx;
        logic [7:0] dev;
        logic [7:0] val;
    } strobe_t;

    function automatic logic [7:0] glob_mask(input logic [7:0] idx);
        case (idx)
            8'h02, 8'h07, 8'h26, 8'h27,
            8'h2B, 8'h2C, 8'h2D, 8'h2E, 8'h2F: glob_mask = 8'hFF;
            8'h22, 8'h23:                      glob_mask = 8'h39;
            8'h24:                             glob_mask = 8'h4E;
            default:                           glob_mask = 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] glob_reset(input logic [7:0] idx, input logic strap);
        case (idx)
            8'h22:   glob_reset = 8'h39;
            8'h24:   glob_reset = 8'h04;
            8'h26:   glob_reset = strap ? 8'h70 : 8'hF0;
            8'h27:   glob_reset = 8'h03;
            default: glob_reset = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
    parameter logic [15:0] ALT_UNLOCK_ADDR = 16'h00FB,
    parameter logic [15:0] ALT_LOCK_ADDR   = 16'h00F9,
    parameter logic [15:0] ALT_INDEX_ADDR  = 16'h00EA,
    parameter logic [15:0] ALT_DATA_ADDR   = 16'h00EB
) (
    input  logic        alt_mode,
    input  logic [15:0] addr,
    input  logic [15:0] base,
    output logic        sel_index,
    output logic        sel_data,
    output logic        sel_unlock,
    output logic        sel_lock
);
    always_comb begin
        sel_unlock = 1'b0;
        sel_lock   = 1'b0;
        if (alt_mode) begin
            sel_index  = (addr == ALT_INDEX_ADDR);
            sel_data   = (addr == ALT_DATA_ADDR);
            sel_unlock = (addr == ALT_UNLOCK_ADDR);
            sel_lock   = (addr == ALT_LOCK_ADDR);
        end else begin
            sel_index = (addr[15:1] == base[15:1]) && !addr[0];
            sel_data  = (addr[15:1] == base[15:1]) &&  addr[0];
        end
    end
endmodule

// File: rtl/cfg_key_fsm.sv
module cfg_key_fsm
    import cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       alt_mode,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] wdata,
    input  logic       sel_index,
    input  logic       sel_data,
    input  logic       sel_unlock,
    input  logic       sel_lock,
    output logic       open,
    output logic [7:0] cur_idx,
    output logic       data_wr
);
    fsm_t fsm_d, fsm_q;
    logic touch;

    always_comb begin
        fsm_d   = fsm_q;
        touch   = io_wr || io_rd;
        data_wr = fsm_q.open && io_wr && sel_data;
        if (alt_mode) begin
            if (touch && sel_unlock)
                fsm_d.open = 1'b1;
            else if (touch && sel_lock)
                fsm_d.open = 1'b0;
            else if (io_wr && sel_index && fsm_q.open)
                fsm_d.idx = wdata;
        end else if (io_wr && sel_index) begin
            if (!fsm_q.open) begin
                if (wdata == KEY_ENTER) fsm_d.open = 1'b1;
            end else if (wdata == KEY_EXIT) begin
                fsm_d.open = 1'b0;
            end else begin
                fsm_d.idx = wdata;
            end
        end
        if (data_wr && fsm_q.idx == IDX_CTRL && wdata == EXIT_VAL)
            fsm_d.open = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) fsm_q <= '0;
        else     fsm_q <= fsm_d;
    end

    assign open    = fsm_q.open;
    assign cur_idx = fsm_q.idx;

    p_enter_key_r3: assert property (@(posedge clk) disable iff (rst)
        !alt_mode && !fsm_q.open && io_wr && sel_index && wdata == KEY_ENTER |=> open);
    p_exit_key_r4: assert property (@(posedge clk) disable iff (rst)
        !alt_mode && fsm_q.open && io_wr && sel_index && wdata == KEY_EXIT |=> !open);
    p_self_exit_r8: assert property (@(posedge clk) disable iff (rst)
        data_wr && fsm_q.idx == IDX_CTRL && wdata == EXIT_VAL |=> !open);
    p_alt_unlock_r11: assert property (@(posedge clk) disable iff (rst)
        alt_mode && (io_wr || io_rd) && sel_unlock |=> open);
endmodule

// File: rtl/cfg_global_regs.sv
module cfg_global_regs
    import cfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        base_strap,
    input  logic        wr_en,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_val,
    output logic [15:0] base,
    output logic [7:0]  dev_sel
);
    logic [7:0] g_d [GLOBAL_N];
    logic [7:0] g_q [GLOBAL_N];
    logic [7:0] wmask;

    always_comb begin
        g_d   = g_q;
        wmask = glob_mask(idx);
        if (wr_en && idx < BANK_START && wmask != 8'h00)
            g_d[idx[5:0]] = wdata & wmask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < GLOBAL_N; i++)
                g_q[i] <= glob_reset(8'(i), base_strap);
        end else begin
            g_q <= g_d;
        end
    end

    always_comb begin
        if (idx == IDX_ID)          rd_val = CHIP_ID;
        else if (idx < BANK_START)  rd_val = g_q[idx[5:0]];
        else                        rd_val = 8'hFF;
    end

    assign base    = {g_q[IDX_BASE_HI[5:0]], g_q[IDX_BASE_LO[5:0]]};
    assign dev_sel = g_q[IDX_DEVSEL[5:0]];

    p_power_mask_r7: assert property (@(posedge clk) disable iff (rst)
        wr_en && idx == 8'h22 |=> (g_q[6'h22] & 8'hC6) == 8'h00);
endmodule

// File: rtl/cfg_device_bank.sv
module cfg_device_bank
    import cfg_pkg::*;
#(
    parameter int NUM_DEV = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] dev,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] rd_val,
    output logic       dev_ok
);
    localparam int DEPTH = 256 - int'(BANK_START);
    localparam int ROW_W = $clog2(DEPTH);
    localparam int DEV_W = $clog2(NUM_DEV);

    logic [7:0]       mem_d [NUM_DEV][DEPTH];
    logic [7:0]       mem_q [NUM_DEV][DEPTH];
    logic [DEV_W-1:0] dev_i;
    logic [ROW_W-1:0] row;
    logic             in_bank;

    always_comb begin
        dev_ok  = (dev < 8'(NUM_DEV));
        in_bank = (idx >= BANK_START);
        dev_i   = dev_ok ? dev[DEV_W-1:0] : '0;
        row     = in_bank ? ROW_W'(idx - BANK_START) : '0;
        mem_d   = mem_q;
        if (wr_en && dev_ok && in_bank)
            mem_d[dev_i][row] = wdata;
        rd_val = (dev_ok && in_bank) ? mem_q[dev_i][row] : 8'hFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < NUM_DEV; d++)
                for (int r = 0; r < DEPTH; r++)
                    mem_q[d][r] <= 8'h00;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
    import cfg_pkg::*;
#(
    parameter int NUM_DEV = 9
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        alt_mode,
    input  logic        base_strap,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    output logic [7:0]  io_rdata,
    output logic        cfg_active,
    output logic        wr_strobe,
    output logic [7:0]  wr_index,
    output logic [7:0]  wr_dev,
    output logic [7:0]  wr_value
);
    logic        sel_index, sel_data, sel_unlock, sel_lock;
    logic        open, data_wr, dev_ok;
    logic [7:0]  cur_idx, glob_rd, bank_rd, dev_sel;
    logic [15:0] base;
    logic        is_glob;
    strobe_t     stb_d, stb_q;

    cfg_port_decode u_decode (
        .alt_mode   (alt_mode),
        .addr       (io_addr),
        .base       (base),
        .sel_index  (sel_index),
        .sel_data   (sel_data),
        .sel_unlock (sel_unlock),
        .sel_lock   (sel_lock)
    );

    cfg_key_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .alt_mode   (alt_mode),
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .wdata      (io_wdata),
        .sel_index  (sel_index),
        .sel_data   (sel_data),
        .sel_unlock (sel_unlock),
        .sel_lock   (sel_lock),
        .open       (open),
        .cur_idx    (cur_idx),
        .data_wr    (data_wr)
    );

    assign is_glob = (cur_idx < BANK_START);

    cfg_global_regs u_glob (
        .clk        (clk),
        .rst        (rst),
        .base_strap (base_strap),
        .wr_en      (data_wr && is_glob),
        .idx        (cur_idx),
        .wdata      (io_wdata),
        .rd_val     (glob_rd),
        .base       (base),
        .dev_sel    (dev_sel)
    );

    cfg_device_bank #(.NUM_DEV(NUM_DEV)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (data_wr && !is_glob),
        .dev    (dev_sel),
        .idx    (cur_idx),
        .wdata  (io_wdata),
        .rd_val (bank_rd),
        .dev_ok (dev_ok)
    );

    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && open) begin
            if (sel_index)     io_rdata = cur_idx;
            else if (sel_data) io_rdata = is_glob ? glob_rd : bank_rd;
        end
    end

    always_comb begin
        stb_d.idx = cur_idx;
        stb_d.dev = dev_sel;
        if (is_glob) begin
            stb_d.val = io_wdata & glob_mask(cur_idx);
            stb_d.stb = data_wr && (glob_mask(cur_idx) != 8'h00);
        end else begin
            stb_d.val = io_wdata;
            stb_d.stb = data_wr && dev_ok;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stb_q <= '0;
        else     stb_q <= stb_d;
    end

    assign cfg_active = open;
    assign wr_strobe  = stb_q.stb;
    assign wr_index   = stb_q.idx;
    assign wr_dev     = stb_q.dev;
    assign wr_value   = stb_q.val;

    p_locked_read_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_active |-> io_rdata == 8'hFF);
    p_no_strobe_locked_r12: assert property (@(posedge clk) disable iff (rst)
        !cfg_active |=> !wr_strobe);
endmodule

// File: tb/cfg_port_ctrl_tb.sv
`timescale 1ns/1ps
module cfg_port_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        alt_mode = 1'b0;
    logic        base_strap = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic        cfg_active, wr_strobe;
    logic [7:0]  wr_index, wr_dev, wr_value;

    always #2.5 clk = ~clk;

    cfg_port_ctrl u_dut (
        .clk(clk), .rst(rst), .alt_mode(alt_mode), .base_strap(base_strap),
        .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .cfg_active(cfg_active), .wr_strobe(wr_strobe),
        .wr_index(wr_index), .wr_dev(wr_dev), .wr_value(wr_value)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // Reference model state
    bit   m_open;
    int   m_idx;
    int   m_g [48];
    int   m_bank [9][256];
    bit   e_stb;
    int   e_idx, e_dev, e_val;
    string last_req = "R1";

    function automatic int mask_of(int i);
        if (i == 'h22 || i == 'h23) return 'h39;
        if (i == 'h24) return 'h4E;
        if (i == 'h02 || i == 'h07 || i == 'h26 || i == 'h27) return 'hFF;
        if (i >= 'h2B && i <= 'h2F) return 'hFF;
        return 0;
    endfunction

    function automatic void model_reset();
        m_open = 0; m_idx = 0; e_stb = 0;
        foreach (m_g[i]) m_g[i] = 0;
        foreach (m_bank[d, r]) m_bank[d][r] = 0;
        m_g['h22] = 'h39; m_g['h24] = 'h04; m_g['h27] = 'h03;
        m_g['h26] = base_strap ? 'h70 : 'hF0;
    endfunction

    function automatic bit hit_index(int a);
        int b = (m_g['h27] * 256 + m_g['h26]) & 'hFFFE;
        return alt_mode ? (a == 'hEA) : (a == b);
    endfunction

    function automatic bit hit_data(int a);
        int b = (m_g['h27] * 256 + m_g['h26]) & 'hFFFE;
        return alt_mode ? (a == 'hEB) : (a == b + 1);
    endfunction

    function automatic int model_read(int a);
        if (!m_open) return 'hFF;
        if (hit_index(a)) return m_idx;
        if (!hit_data(a)) return 'hFF;
        if (m_idx == 'h20) return 'h47;
        if (m_idx < 'h30) return m_g[m_idx];
        if (m_g[7] <= 8) return m_bank[m_g[7]][m_idx];
        return 'hFF;
    endfunction

    function automatic void model_step(bit wr, bit rd, int a, int d);
        bit hx = hit_index(a);
        bit hd = hit_data(a);
        bit was_open = m_open;
        int old_idx = m_idx;
        e_stb = 0;
        if (alt_mode) begin
            if ((wr || rd) && a == 'hFB) m_open = 1;
            else if ((wr || rd) && a == 'hF9) m_open = 0;
            else if (wr && hx && was_open) m_idx = d;
        end else if (wr && hx) begin
            if (!was_open) begin
                if (d == 'h55) m_open = 1;
            end else if (d == 'hAA) m_open = 0;
            else m_idx = d;
        end
        if (wr && hd && was_open) begin
            if (old_idx < 'h30) begin
                if (mask_of(old_idx) != 0) begin
                    e_stb = 1; e_idx = old_idx; e_dev = m_g[7];
                    e_val = d & mask_of(old_idx);
                    m_g[old_idx] = e_val;
                end
                if (old_idx == 2 && d == 2) m_open = 0;
            end else if (m_g[7] <= 8) begin
                e_stb = 1; e_idx = old_idx; e_dev = m_g[7]; e_val = d;
                m_bank[m_g[7]][old_idx] = d;
            end
        end
    endfunction

    task automatic check(string req, string what, int got, int exp);
        compared++;
        if (got != exp) begin
            mismatched++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // One bus cycle, inputs driven at the falling edge.
    task automatic step(bit wr, bit rd, int a, int d, string req);
        // registered outputs from the previous edge
        check(last_req, "cfg_active", cfg_active, m_open);
        check(last_req, "wr_strobe", wr_strobe, e_stb);
        if (e_stb) begin
            check(last_req, "wr_index", wr_index, e_idx);
            check(last_req, "wr_dev", wr_dev, e_dev);
            check(last_req, "wr_value", wr_value, e_val);
        end
        io_wr = wr; io_rd = rd; io_addr = 16'(a); io_wdata = 8'(d);
        #1;
        if (rd) check(req, "io_rdata", io_rdata, model_read(a));
        model_step(wr, rd, a, d);
        last_req = req;
        @(posedge clk);
        @(negedge clk);
        io_wr = 0; io_rd = 0;
    endtask

    task automatic wr_io(int a, int d, string req); step(1, 0, a, d, req); endtask
    task automatic rd_io(int a, string req);        step(0, 1, a, 0, req); endtask
    task automatic reg_wr(int ix, int dx, int i, int d, string req);
        wr_io(ix, i, req); wr_io(dx, d, req);
    endtask
    task automatic reg_rd(int ix, int dx, int i, string req);
        wr_io(ix, i, req); rd_io(dx, req);
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    localparam int IX = 'h3F0;
    localparam int DX = 'h3F1;

    initial begin
        model_reset();
        do_reset();
        // R1 / R5: locked after reset
        rd_io(IX, "R5"); rd_io(DX, "R5");
        wr_io(DX, 'h12, "R5");
        // R3: key on the data port or wrong byte does not unlock
        wr_io(DX, 'h55, "R3"); rd_io(IX, "R3");
        wr_io(IX, 'h56, "R3"); rd_io(IX, "R3");
        wr_io(IX, 'h55, "R3"); rd_io(IX, "R4");
        // R1 reset values
        reg_rd(IX, DX, 'h22, "R1"); reg_rd(IX, DX, 'h24, "R1");
        reg_rd(IX, DX, 'h26, "R1"); reg_rd(IX, DX, 'h27, "R1");
        reg_rd(IX, DX, 'h02, "R1");
        // R6: identifier
        reg_rd(IX, DX, 'h20, "R6"); wr_io(DX, 'h00, "R6"); rd_io(DX, "R6");
        // R7: masks
        reg_wr(IX, DX, 'h22, 'hFF, "R7"); rd_io(DX, "R7");
        reg_wr(IX, DX, 'h23, 'hC7, "R7"); rd_io(DX, "R7");
        reg_wr(IX, DX, 'h24, 'hFF, "R7"); rd_io(DX, "R7");
        reg_wr(IX, DX, 'h2B, 'hA5, "R7"); rd_io(DX, "R7");
        reg_wr(IX, DX, 'h21, 'h5A, "R7"); rd_io(DX, "R7");
        reg_wr(IX, DX, 'h28, 'h11, "R7"); rd_io(DX, "R7");
        // R2: neighbouring address ignored
        wr_io('h3F2, 'h2B, "R2"); rd_io(IX, "R2"); rd_io('h3F3, "R2");
        // R10: device banks
        reg_wr(IX, DX, 'h07, 3, "R10"); reg_wr(IX, DX, 'h60, 'h12, "R10");
        reg_wr(IX, DX, 'h07, 8, "R10"); reg_wr(IX, DX, 'h60, 'h34, "R10");
        reg_wr(IX, DX, 'hFF, 'hC3, "R10");
        reg_wr(IX, DX, 'h07, 3, "R10"); reg_rd(IX, DX, 'h60, "R10");
        reg_wr(IX, DX, 'h07, 9, "R10"); reg_wr(IX, DX, 'h60, 'h99, "R10");
        rd_io(DX, "R10");
        reg_wr(IX, DX, 'h07, 8, "R10"); reg_rd(IX, DX, 'h60, "R10");
        reg_rd(IX, DX, 'hFF, "R10");
        // R4: 0x55 while open just selects, 0xAA locks
        wr_io(IX, 'h55, "R4"); rd_io(IX, "R4");
        wr_io(IX, 'hAA, "R4"); rd_io(IX, "R4");
        wr_io(DX, 'h77, "R5");
        wr_io(IX, 'h55, "R4"); rd_io(DX, "R5");
        // R8: self exit
        reg_wr(IX, DX, 'h02, 'h01, "R8"); rd_io(DX, "R8");
        wr_io(DX, 'h02, "R8"); rd_io(DX, "R8"); rd_io(IX, "R8");
        wr_io(IX, 'h55, "R8"); reg_rd(IX, DX, 'h02, "R8");
        // R9: relocate to 0x0270
        reg_wr(IX, DX, 'h26, 'h71, "R9");
        rd_io(IX, "R9"); rd_io('h370, "R9");
        wr_io('h370, 'h27, "R9"); reg_wr('h370, 'h371, 'h27, 'h02, "R9");
        rd_io('h370, "R9"); reg_rd('h270, 'h271, 'h26, "R9");
        wr_io('h270, 'hAA, "R9"); rd_io('h270, "R9");
        // R11: alternate scheme, strapped base
        alt_mode = 1; base_strap = 1;
        do_reset();
        wr_io('hEA, 'h55, "R11"); rd_io('hEA, "R11");
        rd_io('hFB, "R11"); rd_io('hEA, "R11");
        reg_rd('hEA, 'hEB, 'h26, "R11");
        wr_io('hEA, 'hAA, "R11"); rd_io('hEA, "R11");
        reg_wr('hEA, 'hEB, 'h07, 1, "R11"); reg_wr('hEA, 'hEB, 'hAA, 'h3C, "R11");
        rd_io('hEB, "R11");
        reg_rd('h370, 'h371, 'h22, "R11");
        wr_io('hF9, 0, "R11"); rd_io('hEB, "R11");
        wr_io('hFB, 0, "R11"); rd_io('hEB, "R11");
        reg_wr('hEA, 'hEB, 'h02, 'h02, "R11"); rd_io('hEA, "R11");
        // R12 strobe fields checked throughout; final idle flushes last one
        step(0, 0, 0, 0, "R12");
        step(0, 0, 0, 0, "R12");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule